// File: doc/BRIEF.md
# Four-Channel Quadrature Position Counter

This block turns quadrature signals from up to four rotary encoders into signed 8-bit position counts that a host reads and writes over a simple byte-wide register port. A bank of general-purpose input pins is synchronised once. Each channel then picks its own A and B phase pins from that bank through a per-channel configuration byte. The chosen phase pair is decoded as a Gray-code sequence into up and down steps.

A shared enable byte carries two bits per channel. One bit runs the channel. The other chooses between counting every quadrature edge (microstep mode) and counting one step per completed four-edge cycle (detent mode). A disabled channel freezes its count but keeps tracking its phase state, so turning it back on produces no phantom step.

A host write to a count register loads the written byte, so writing zero clears the position. Host software extends the 8-bit value beyond its wrap when it needs a wider range.

Top module: `qenc_bank`

## Requirements
- R1: After synchronous reset, every register reads 0x00: the enable byte, all configuration bytes and all counts.
- R2: The enable byte sits at 0x04. Channel n has its configuration byte at 0x05+2n and its count at 0x06+2n. Configuration and enable bytes read back as written. Any other address reads 0x00. Read data appears on the clock edge after the address is presented.
- R3: In a configuration byte, bits 3:0 give the input pin index used as phase A and bits 7:4 give the index used as phase B.
- R4: Enable bit 2n runs channel n and bit 2n+1 selects microstep mode. In microstep mode the count rises by one for each transition along the (A,B) order 00→10→11→01→00 and falls by one for each transition in the reverse order. Each change is visible in the count within three clock cycles of the pin change.
- R5: In detent mode the count moves by one only after four consecutive net steps in one direction. Back-and-forth motion that returns to the starting phase leaves the count unchanged.
- R6: A sample in which A and B both change leaves the count unchanged.
- R7: The count is two's complement and wraps silently: +127 plus one step gives -128 (0x80), and -128 minus one step gives +127 (0x7F).
- R8: While a channel's run bit is clear, its count holds regardless of pin activity. After it is re-enabled, only new transitions count.
- R9: Writing a count register loads the written byte, so writing 0x00 clears it. The write wins over a step in the same cycle and discards any partial detent progress.
- R10: Channels are independent: activity on one channel's pins never alters another channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | 16 | Asynchronous input pin bank |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |

## Verification
The bench sweeps every channel forward and backward through the phase order and checks the count after each step. This catches a swapped direction or a swapped A/B nibble, which would count the wrong way or not at all. It crosses +127 and -128 in both directions, where a saturating or widened counter would stick or carry.

In detent mode, jitter around one phase must net to zero. A decoder that counted entries into the rest phase would drift there. Double-edge samples, pin activity on a disabled channel, and a count write landing on the same edge as a step are each driven on purpose. A wrong design would either count the illegal jump, count while stopped, or let the step override the loaded value.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {MV_NONE, MV_UP, MV_DOWN, MV_BAD} move_e;

  // Position of an (A,B) pair along the counting-up order 00,10,11,01.
  function automatic logic [1:0] phase_index(input logic a, input logic b);
    logic [1:0] idx;
    case ({a, b})
      2'b00:   idx = 2'd0;
      2'b10:   idx = 2'd1;
      2'b11:   idx = 2'd2;
      default: idx = 2'd3;
    endcase
    return idx;
  endfunction

  function automatic move_e classify(input logic [1:0] old_i, input logic [1:0] new_i);
    logic [1:0] d;
    move_e m;
    d = new_i - old_i;
    case (d)
      2'd0:    m = MV_NONE;
      2'd1:    m = MV_UP;
      2'd3:    m = MV_DOWN;
      default: m = MV_BAD;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qenc_channel.sv
module qenc_channel
  import qenc_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int CW       = 8,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins,
  input  logic [PIN_W-1:0]    sel_a,
  input  logic [PIN_W-1:0]    sel_b,
  input  logic                run,
  input  logic                micro,
  input  logic                load,
  input  logic [CW-1:0]       load_val,
  output logic [CW-1:0]       count
);
  logic              a_now, b_now;
  logic [1:0]        prev_idx, cur_idx;
  move_e             mv;
  logic signed [2:0] sub, sub_nxt;
  logic              bump_up, bump_dn;

  assign a_now   = pins[sel_a];
  assign b_now   = pins[sel_b];
  assign cur_idx = phase_index(a_now, b_now);
  assign mv      = classify(prev_idx, cur_idx);

  always_comb begin
    bump_up = 1'b0;
    bump_dn = 1'b0;
    sub_nxt = sub;
    if (run) begin
      if (micro) begin
        sub_nxt = '0;
        bump_up = (mv == MV_UP);
        bump_dn = (mv == MV_DOWN);
      end else if (mv == MV_UP) begin
        if (sub == 3'sd3) begin
          sub_nxt = '0;
          bump_up = 1'b1;
        end else begin
          sub_nxt = sub + 3'sd1;
        end
      end else if (mv == MV_DOWN) begin
        if (sub == -3'sd3) begin
          sub_nxt = '0;
          bump_dn = 1'b1;
        end else begin
          sub_nxt = sub - 3'sd1;
        end
      end
    end
  end

  // Phase history always follows the pins so re-enabling sees no jump.
  always_ff @(posedge clk) begin
    if (rst) prev_idx <= 2'd0;
    else     prev_idx <= cur_idx;
  end

  always_ff @(posedge clk) begin
    if (rst || load) sub <= '0;
    else             sub <= sub_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (load)    count <= load_val;
    else if (bump_up) count <= count + CW'(1);
    else if (bump_dn) count <= count - CW'(1);
  end

  assert_hold_when_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count == $past(count)) || (count == $past(count) + CW'(1))
              || (count == $past(count) - CW'(1)));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val));

  assert_bad_move_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (mv == MV_BAD && !load) |=> $stable(count));

  assert_detent_range_R5: assert property (@(posedge clk) disable iff (rst)
    (sub >= -3'sd3) && (sub <= 3'sd3));

endmodule

// File: rtl/qenc_regs.sv
module qenc_regs #(
  parameter int NUM_CH    = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 4,
  localparam int EN_W     = 2 * NUM_CH
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic [NUM_CH*DATA_W-1:0] counts,
  output logic [NUM_CH-1:0]        run_mask,
  output logic [NUM_CH-1:0]        micro_mask,
  output logic [NUM_CH*DATA_W-1:0] cfg_flat,
  output logic [NUM_CH-1:0]        load_mask,
  output logic [DATA_W-1:0]        bus_rdata
);
  logic [EN_W-1:0]   en_q;
  logic [DATA_W-1:0] cfg_q [NUM_CH];
  logic              hit_en, hit_any;
  logic [NUM_CH-1:0] hit_cfg, hit_cnt;
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    hit_en = (bus_addr == ADDR_W'(BASE_ADDR));
    for (int ch = 0; ch < NUM_CH; ch++) begin
      hit_cfg[ch] = (bus_addr == ADDR_W'(BASE_ADDR + 1 + 2*ch));
      hit_cnt[ch] = (bus_addr == ADDR_W'(BASE_ADDR + 2 + 2*ch));
    end
    hit_any = hit_en || (|hit_cfg) || (|hit_cnt);
  end

  always_comb begin
    rd_nxt = '0;
    if (hit_en) rd_nxt = DATA_W'(en_q);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (hit_cfg[ch]) rd_nxt = cfg_q[ch];
      if (hit_cnt[ch]) rd_nxt = counts[ch*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      bus_rdata <= '0;
      for (int ch = 0; ch < NUM_CH; ch++) cfg_q[ch] <= '0;
    end else begin
      bus_rdata <= rd_nxt;
      if (bus_we && hit_en) en_q <= bus_wdata[EN_W-1:0];
      for (int ch = 0; ch < NUM_CH; ch++)
        if (bus_we && hit_cfg[ch]) cfg_q[ch] <= bus_wdata;
    end
  end

  assign load_mask = hit_cnt & {NUM_CH{bus_we}};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_unpack
    assign run_mask[ch]                   = en_q[2*ch];
    assign micro_mask[ch]                 = en_q[2*ch+1];
    assign cfg_flat[ch*DATA_W +: DATA_W]  = cfg_q[ch];
  end

  assert_unmapped_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !hit_any |=> bus_rdata == '0);

  assert_enable_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (hit_en && !bus_we) |=> bus_rdata == DATA_W'(en_q));

endmodule

// File: rtl/qenc_bank.sv
module qenc_bank #(
  parameter int NUM_CH      = 4,
  parameter int NUM_PINS    = 16,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BASE_ADDR   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_in,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata
);
  localparam int PIN_W   = $clog2(NUM_PINS);
  localparam int FIELD_W = DATA_W / 2;

  logic [NUM_PINS-1:0]        pins_s;
  logic [NUM_CH-1:0]          run_mask, micro_mask, load_mask;
  logic [NUM_CH*DATA_W-1:0]   cfg_flat, counts;

  qenc_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pins_in), .q(pins_s)
  );

  qenc_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
              .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .counts(counts), .run_mask(run_mask),
    .micro_mask(micro_mask), .cfg_flat(cfg_flat), .load_mask(load_mask),
    .bus_rdata(bus_rdata)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    qenc_channel #(.NUM_PINS(NUM_PINS), .CW(DATA_W)) u_chan (
      .clk(clk), .rst(rst), .pins(pins_s),
      .sel_a(cfg_flat[ch*DATA_W +: PIN_W]),
      .sel_b(cfg_flat[ch*DATA_W + FIELD_W +: PIN_W]),
      .run(run_mask[ch]), .micro(micro_mask[ch]), .load(load_mask[ch]),
      .load_val(bus_wdata), .count(counts[ch*DATA_W +: DATA_W])
    );
  end
endmodule

// File: tb/sim_qenc_bank.sv
module sim_qenc_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pins_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int pa [4] = '{0, 2, 4, 15};
  int pb [4] = '{1, 3, 5, 14};
  int idx [4] = '{0, 0, 0, 0};
  int exp_c [4] = '{0, 0, 0, 0};
  int sub_c [4] = '{0, 0, 0, 0};
  bit run_c [4] = '{0, 0, 0, 0};
  bit mic_c [4] = '{0, 0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  qenc_bank u0 (
    .clk(clk), .rst(rst), .pins_in(pins_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic set_en(logic [7:0] v);
    for (int c = 0; c < 4; c++) begin
      run_c[c] = v[2*c];
      mic_c[c] = v[2*c+1];
    end
    wr(8'h04, v);
  endtask

  task automatic drive_phase(int ch);
    case (idx[ch])
      0: begin pins_in[pa[ch]] = 1'b0; pins_in[pb[ch]] = 1'b0; end
      1: begin pins_in[pa[ch]] = 1'b1; pins_in[pb[ch]] = 1'b0; end
      2: begin pins_in[pa[ch]] = 1'b1; pins_in[pb[ch]] = 1'b1; end
      default: begin pins_in[pa[ch]] = 1'b0; pins_in[pb[ch]] = 1'b1; end
    endcase
  endtask

  task automatic model_move(int ch, int dir);
    if (run_c[ch]) begin
      if (mic_c[ch]) exp_c[ch] += dir;
      else begin
        sub_c[ch] += dir;
        if (sub_c[ch] == 4)  begin exp_c[ch] += 1; sub_c[ch] = 0; end
        if (sub_c[ch] == -4) begin exp_c[ch] -= 1; sub_c[ch] = 0; end
      end
    end
  endtask

  task automatic step(int ch, int dir);
    idx[ch] = (idx[ch] + dir + 4) % 4;
    drive_phase(ch);
    model_move(ch, dir);
    repeat (4) @(negedge clk);
  endtask

  task automatic load_cnt(int ch, logic [7:0] v);
    wr(8'(6 + 2*ch), v);
    exp_c[ch] = int'($signed(v));
    sub_c[ch] = 0;
  endtask

  task automatic chk_cnt(int ch, string req);
    logic [7:0] v;
    rd(8'(6 + 2*ch), v);
    chk(req, $sformatf("count ch%0d", ch), v, 8'(exp_c[ch]));
  endtask

  task automatic chk_all(string req);
    for (int c = 0; c < 4; c++) chk_cnt(c, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: every register is zero out of reset
    for (int a = 4; a <= 12; a++) begin
      rd(8'(a), v);
      chk("R1", $sformatf("reset value at %0h", a), v, 8'h00);
    end

    // R2 / R3: configuration; A index low nibble, B index high nibble
    wr(8'h05, 8'h10);
    wr(8'h07, 8'h32);
    wr(8'h09, 8'h54);
    wr(8'h0B, 8'hEF);
    rd(8'h05, v); chk("R2", "cfg ch0 readback", v, 8'h10);
    rd(8'h0B, v); chk("R2", "cfg ch3 readback", v, 8'hEF);
    set_en(8'hDF);
    rd(8'h04, v); chk("R2", "enable readback", v, 8'hDF);
    rd(8'h03, v); chk("R2", "unmapped 0x03", v, 8'h00);
    rd(8'hFF, v); chk("R2", "unmapped 0xFF", v, 8'h00);
    repeat (4) @(negedge clk);
    chk_all("R1");

    // R4 / R3 / R10: microstep sweeps on channels 0, 1, 3
    for (int ci = 0; ci < 3; ci++) begin
      int ch;
      ch = (ci == 2) ? 3 : ci;
      for (int k = 0; k < 9; k++) begin
        step(ch, 1);
        chk_cnt(ch, (ch == 3) ? "R3" : "R4");
      end
      for (int k = 0; k < 12; k++) begin
        step(ch, -1);
        chk_cnt(ch, "R4");
      end
      chk_all("R10");
    end

    // R5: detent mode on channel 2
    for (int k = 0; k < 8; k++) begin
      step(2, 1);
      chk_cnt(2, "R5");
    end
    for (int k = 0; k < 6; k++) begin
      step(2, (k % 2 == 0) ? 1 : -1);
      chk_cnt(2, "R5");
    end
    for (int k = 0; k < 9; k++) begin
      step(2, -1);
      chk_cnt(2, "R5");
    end
    chk_all("R10");

    // R6: both phases flip in one sample
    for (int k = 0; k < 3; k++) begin
      idx[0] = (idx[0] + 2) % 4;
      drive_phase(0);
      repeat (4) @(negedge clk);
      chk_cnt(0, "R6");
      step(0, 1);
      chk_cnt(0, "R6");
    end

    // R7: wrap in both directions
    load_cnt(1, 8'd125);
    for (int k = 0; k < 5; k++) begin
      step(1, 1);
      exp_c[1] = int'($signed(8'(exp_c[1])));
      chk_cnt(1, "R7");
    end
    load_cnt(1, 8'h81);
    for (int k = 0; k < 3; k++) begin
      step(1, -1);
      exp_c[1] = int'($signed(8'(exp_c[1])));
      chk_cnt(1, "R7");
    end

    // R8: stopped channel ignores its pins
    set_en(8'hDC);
    for (int k = 0; k < 5; k++) begin
      step(0, 1);
      chk_cnt(0, "R8");
    end
    set_en(8'hDF);
    repeat (4) @(negedge clk);
    chk_cnt(0, "R8");
    step(0, 1);
    chk_cnt(0, "R8");

    // R9: write lands on the same edge as a step
    idx[0] = (idx[0] + 1) % 4;
    drive_phase(0);
    @(negedge clk);
    @(negedge clk);
    load_cnt(0, 8'h40);
    repeat (3) @(negedge clk);
    chk_cnt(0, "R9");
    load_cnt(0, 8'h00);
    chk_cnt(0, "R9");
    // R9: write discards partial detent progress
    for (int k = 0; k < 3; k++) step(2, 1);
    load_cnt(2, 8'h00);
    step(2, 1);
    chk_cnt(2, "R9");
    for (int k = 0; k < 3; k++) step(2, 1);
    chk_cnt(2, "R9");
    chk_all("R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule